// File: doc/BRIEF.md
# Microcoded 8-bit ALU

This block is the arithmetic and logic unit of a small microcoded 8-bit processor. Every cycle the microsequencer presents an 8-bit control field together with two operands that outside multiplexers have already chosen. The unit conditions each operand, computes one result and registers it with the flag-side values: the carry, the half carry, a zero indication and the tested bit.

The control field is not a list of opcodes. Its top two bits pick one of four primitives: exclusive-or, AND, add, or a miscellaneous group. Four further bits mask and invert each operand bit-wise as `(b & k) ^ c`. Subtraction, complement, clear, rotate-through and fill variants all come from that conditioning rather than from separate operations.

In the miscellaneous group the low control bits are reused as a sub-operation code. The group holds left and right shifts, a nibble swap, an arithmetic right shift, and a single-bit replace that also reports the bit. Results load on a rising clock edge when the enable is high and hold otherwise.

Top module: `uc_alu`

## Requirements
- R1: While reset is asserted and until the first enabled edge after it, `res_o`=0, `cy_o`=0, `hc_o`=0, `bit_o`=0 and `z_o`=1.
- R2: In every mode the left operand becomes `(L & ctl[5]) ^ ctl[4]` and the right operand becomes `(opr & ctl[3]) ^ ctl[2]`, applied bit-wise. L is `opl`, except in the shift case of R7/R8.
- R3: `ctl[7:6]` selects the primitive: 0 = exclusive-or of the conditioned operands, 2 = AND, 3 = add, 1 = miscellaneous group.
- R4: In AND mode with `ctl[0]`=1 the result is the bit-wise complement of the AND.
- R5: The adder sums the conditioned operands plus `ctl[1]` as carry-in. In add mode the result is the low 8 bits, `cy_o` is the carry out of bit 7 and `hc_o` is the carry out of bit 3.
- R6: `hc_o` in every mode, and `cy_o` in every mode except the three shifts, hold the adder's carries for the current operands, even when the result comes from another primitive.
- R7: Miscellaneous with `ctl[1:0]`=00 is a left shift. The left operand source becomes `opr` before conditioning. Result = {R'[6:0], L'[7]} and `cy_o` = R'[7].
- R8: Miscellaneous with `ctl[1:0]`=10 is a right shift with the same source substitution. Result = {L'[0], R'[7:1]} and `cy_o` = R'[0].
- R9: Miscellaneous with `ctl[2:0]`=001 swaps the two nibbles of R'.
- R10: Miscellaneous with `ctl[2:0]`=011 is an arithmetic right shift of R': the top bit is kept and `cy_o` = R'[0].
- R11: Miscellaneous with `ctl[2]`=1 and `ctl[0]`=1 writes `ctl[1]` into bit number `ctl[5:3]` of R'. `bit_o` reports the old value of that bit. In all other modes `bit_o` is 0.
- R12: `z_o` is 1 exactly when the registered 8-bit result is zero.
- R13: Outputs load on a rising edge where `en`=1 and keep their value on edges where `en`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Load enable for the result registers |
| ctl | input | 8 | Microcode ALU control field |
| opl | input | 8 | Left operand from the operand multiplexer |
| opr | input | 8 | Right operand from the operand multiplexer |
| res_o | output | 8 | Registered result |
| cy_o | output | 1 | Registered carry (adder carry or shifted-out bit) |
| hc_o | output | 1 | Registered half carry of the adder |
| z_o | output | 1 | Registered zero indication of the result |
| bit_o | output | 1 | Registered original value of the tested bit |

## Verification
All five outputs are due together at the first rising edge that samples `en` high with the stimulus in place, one register stage after the inputs. They then stay valid until the next enabled edge. The bench drives control and operands on the falling edge and compares every output at the following falling edge, half a period after the loading edge and before new inputs arrive. On cycles with `en` low the model keeps its previous expectation, so the hold behaviour is checked at the same sampling point.

// File: rtl/uc_alu_pkg.sv
package uc_alu_pkg;

  localparam int CTL_W = 8;

  typedef enum logic [1:0] {
    OP_XOR  = 2'd0,
    OP_MISC = 2'd1,
    OP_AND  = 2'd2,
    OP_ADD  = 2'd3
  } alu_op_e;

  typedef enum logic [2:0] {
    MS_SHL,
    MS_SHR,
    MS_SWAP,
    MS_ASR,
    MS_BIT
  } misc_sel_e;

  // Sub-operation decode of the miscellaneous group from ctl[2:0]
  function automatic misc_sel_e misc_decode(input logic [2:0] lo);
    misc_sel_e s;
    if (!lo[0])      s = lo[1] ? MS_SHR : MS_SHL;
    else if (lo[2])  s = MS_BIT;
    else             s = lo[1] ? MS_ASR : MS_SWAP;
    return s;
  endfunction

endpackage

// File: rtl/uc_alu_opcond.sv
module uc_alu_opcond #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  input  logic         keep,
  input  logic         flip,
  output logic [W-1:0] dout
);
  // Bit-wise mask then invert, one cell per bit
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = (din[i] & keep) ^ flip;
  end
endmodule

// File: rtl/uc_alu_adder.sv
module uc_alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         hcout
);
  localparam int HW = W / 2;

  logic [W:0]  full;
  logic [HW:0] half;

  always_comb begin
    full  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    half  = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, cin};
    sum   = full[W-1:0];
    cout  = full[W];
    hcout = half[HW];
  end
endmodule

// File: rtl/uc_alu_misc.sv
module uc_alu_misc
  import uc_alu_pkg::*;
#(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  misc_sel_e     sel,
  input  logic [W-1:0]  lc,
  input  logic [W-1:0]  rc,
  input  logic [IW-1:0] idx,
  input  logic          bval,
  output logic [W-1:0]  res,
  output logic          sh_cy,
  output logic          sh_cy_vld,
  output logic          bit_old
);
  localparam int HW = W / 2;

  logic [W-1:0] bit_wr;

  always_comb begin
    bit_wr      = rc;
    bit_wr[idx] = bval;
  end

  always_comb begin
    res       = rc;
    sh_cy     = 1'b0;
    sh_cy_vld = 1'b0;
    bit_old   = 1'b0;
    unique case (sel)
      MS_SHL: begin
        res       = {rc[W-2:0], lc[W-1]};
        sh_cy     = rc[W-1];
        sh_cy_vld = 1'b1;
      end
      MS_SHR: begin
        res       = {lc[0], rc[W-1:1]};
        sh_cy     = rc[0];
        sh_cy_vld = 1'b1;
      end
      MS_ASR: begin
        res       = {rc[W-1], rc[W-1:1]};
        sh_cy     = rc[0];
        sh_cy_vld = 1'b1;
      end
      MS_SWAP: res = {rc[HW-1:0], rc[W-1:HW]};
      MS_BIT: begin
        res     = bit_wr;
        bit_old = rc[idx];
      end
      default: res = rc;
    endcase
  end
endmodule

// File: rtl/uc_alu.sv
module uc_alu
  import uc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CTL_W-1:0] ctl,
  input  logic [DW-1:0] opl,
  input  logic [DW-1:0] opr,
  output logic [DW-1:0] res_o,
  output logic          cy_o,
  output logic          hc_o,
  output logic          z_o,
  output logic          bit_o
);
  localparam int IW = $clog2(DW);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  // Control decode
  alu_op_e   op;
  misc_sel_e msel;
  logic      shift_mode;
  logic [DW-1:0] lsrc;
  logic [IW-1:0] bidx;

  always_comb begin
    op         = alu_op_e'(ctl[7:6]);
    msel       = misc_decode(ctl[2:0]);
    shift_mode = (op == OP_MISC) && !ctl[0];
    lsrc       = shift_mode ? opr : opl;
    bidx       = IW'(ctl[5:3]);
  end

  // Operand conditioning
  logic [DW-1:0] lc, rc;

  uc_alu_opcond #(.W(DW)) u_cond_l (
    .din (lsrc),
    .keep(ctl[5]),
    .flip(ctl[4]),
    .dout(lc)
  );

  uc_alu_opcond #(.W(DW)) u_cond_r (
    .din (opr),
    .keep(ctl[3]),
    .flip(ctl[2]),
    .dout(rc)
  );

  // Primitives
  logic [DW-1:0] add_sum;
  logic          add_cy, add_hc;

  uc_alu_adder #(.W(DW)) u_add (
    .a    (lc),
    .b    (rc),
    .cin  (ctl[1]),
    .sum  (add_sum),
    .cout (add_cy),
    .hcout(add_hc)
  );

  logic [DW-1:0] m_res;
  logic          m_cy, m_cy_vld, m_bit;

  uc_alu_misc #(.W(DW), .IW(IW)) u_misc (
    .sel      (msel),
    .lc       (lc),
    .rc       (rc),
    .idx      (bidx),
    .bval     (ctl[1]),
    .res      (m_res),
    .sh_cy    (m_cy),
    .sh_cy_vld(m_cy_vld),
    .bit_old  (m_bit)
  );

  // Next-state
  logic [DW-1:0] res_n;
  logic          cy_n, hc_n, z_n, bit_n;

  always_comb begin
    res_n = add_sum;
    cy_n  = add_cy;
    hc_n  = add_hc;
    bit_n = 1'b0;
    unique case (op)
      OP_XOR:  res_n = lc ^ rc;
      OP_AND:  res_n = (lc & rc) ^ {DW{ctl[0]}};
      OP_ADD:  res_n = add_sum;
      OP_MISC: begin
        res_n = m_res;
        bit_n = m_bit;
        if (m_cy_vld) cy_n = m_cy;
      end
      default: res_n = add_sum;
    endcase
    z_n = (res_n == '0);
  end

  // Registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_o <= '0;
      cy_o  <= 1'b0;
      hc_o  <= 1'b0;
      z_o   <= 1'b1;
      bit_o <= 1'b0;
    end else if (en) begin
      res_o <= res_n;
      cy_o  <= cy_n;
      hc_o  <= hc_n;
      z_o   <= z_n;
      bit_o <= bit_n;
    end
  end
endmodule

// File: rtl/uc_alu_chk.sv
module uc_alu_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          en,
  input logic [7:0]    ctl,
  input logic [DW-1:0] opl,
  input logic [DW-1:0] opr,
  input logic [DW-1:0] res_o,
  input logic          cy_o,
  input logic          z_o
);
  localparam int HW = DW / 2;

  // R12: zero indication tracks the registered result
  p_zero_match_r12: assert property (@(posedge clk) disable iff (!rst_sn)
    z_o == (res_o == '0));

  // R13: no load without enable
  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_sn)
    !en |=> ($stable(res_o) && $stable(cy_o) && $stable(z_o)));

  // R4: plain operands, AND with complement
  p_nand_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (en && ctl == 8'hA9) |=> res_o == ~($past(opl) & $past(opr)));

  // R5: plain operands, add without carry-in
  p_add_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (en && ctl == 8'hE8) |=> {cy_o, res_o} == ({1'b0, $past(opl)} + {1'b0, $past(opr)}));

  // R9: nibble swap of the plain right operand
  p_swap_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (en && ctl == 8'h49) |=> res_o == {$past(opr[HW-1:0]), $past(opr[DW-1:HW])});
endmodule

bind uc_alu uc_alu_chk #(.DW(DW)) u_chk (
  .clk   (clk),
  .rst_sn(rst_sync_n),
  .en    (en),
  .ctl   (ctl),
  .opl   (opl),
  .opr   (opr),
  .res_o (res_o),
  .cy_o  (cy_o),
  .z_o   (z_o)
);

// File: tb/uc_alu_tb.sv
`timescale 1ns/1ps
module uc_alu_tb;
  localparam real TCK = 20.0;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [7:0] ctl, opl, opr;
  logic [7:0] res_o;
  logic       cy_o, hc_o, z_o, bit_o;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;
  logic [11:0] exp_q;

  always #(TCK/2) clk = ~clk;

  uc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .ctl(ctl), .opl(opl), .opr(opr),
    .res_o(res_o), .cy_o(cy_o), .hc_o(hc_o), .z_o(z_o), .bit_o(bit_o)
  );

  // Behavioural reference: {res[7:0], cy, hc, z, bit}
  function automatic logic [11:0] ref_alu(input logic [7:0] c, input logic [7:0] a, input logic [7:0] b);
    int op, lv, lcv, rcv, s, res, cy, hc, bt, idx, m;
    op  = int'(c[7:6]);
    lv  = (op == 1 && c[0] == 1'b0) ? int'(b) : int'(a);
    lcv = c[5] ? lv : 0;
    if (c[4]) lcv = lcv ^ 255;
    rcv = c[3] ? int'(b) : 0;
    if (c[2]) rcv = rcv ^ 255;
    s   = lcv + rcv + int'(c[1]);
    cy  = (s > 255) ? 1 : 0;
    hc  = ((lcv % 16) + (rcv % 16) + int'(c[1]) > 15) ? 1 : 0;
    bt  = 0;
    res = 0;
    case (op)
      0: res = lcv ^ rcv;
      2: begin res = lcv & rcv; if (c[0]) res = res ^ 255; end
      3: res = s % 256;
      default: begin
        if (c[1:0] == 2'b00) begin
          res = (rcv * 2) % 256 + lcv / 128; cy = rcv / 128;
        end else if (c[1:0] == 2'b10) begin
          res = (lcv % 2) * 128 + rcv / 2; cy = rcv % 2;
        end else if (c[2:0] == 3'b001) begin
          res = (rcv % 16) * 16 + rcv / 16;
        end else if (c[2:0] == 3'b011) begin
          res = (rcv / 128) * 128 + rcv / 2; cy = rcv % 2;
        end else begin
          idx = int'(c[5:3]);
          m   = 1 << idx;
          bt  = ((rcv & m) != 0) ? 1 : 0;
          res = c[1] ? (rcv | m) : (rcv & (255 - m));
        end
      end
    endcase
    return {8'(res), 1'(cy), 1'(hc), (res == 0), 1'(bt)};
  endfunction

  function automatic logic [11:0] outs();
    return {res_o, cy_o, hc_o, z_o, bit_o};
  endfunction

  task automatic check(input string req);
    nvec++;
    if (outs() !== exp_q) begin
      nbad++;
      $display("FAIL %s: got res=%02h cy=%b hc=%b z=%b bit=%b, expected res=%02h cy=%b hc=%b z=%b bit=%b",
               req, res_o, cy_o, hc_o, z_o, bit_o,
               exp_q[11:4], exp_q[3], exp_q[2], exp_q[1], exp_q[0]);
    end
  endtask

  // Called at a falling edge; compares at the next falling edge
  task automatic step(input logic [7:0] c, input logic [7:0] a, input logic [7:0] b,
                      input logic e, input string req);
    ctl = c; opl = a; opr = b; en = e;
    if (e) exp_q = ref_alu(c, a, b);
    @(negedge clk);
    check(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    #(TCK * 200000);
    nbad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; ctl = 8'h00; opl = 8'h00; opr = 8'h00;
    exp_q = {8'h00, 1'b0, 1'b0, 1'b1, 1'b0};
    repeat (3) @(negedge clk);
    check("R1 in reset");
    // enable high during reset must not load
    en = 1'b1; ctl = 8'h28; opl = 8'h5A; opr = 8'h0F;
    @(negedge clk);
    check("R1 in reset with en");
    en = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release");

    step(8'h28, 8'hA5, 8'h3C, 1'b1, "R3 xor");
    step(8'h38, 8'hA5, 8'h3C, 1'b1, "R2 left invert");
    step(8'h20, 8'hA5, 8'h3C, 1'b1, "R2 right masked");
    step(8'h14, 8'h12, 8'h34, 1'b1, "R2 both constants");
    step(8'hA8, 8'hF0, 8'h3C, 1'b1, "R3 and");
    step(8'hA9, 8'hF0, 8'h3C, 1'b1, "R4 and complement");
    step(8'hE8, 8'h12, 8'h34, 1'b1, "R5 add");
    step(8'hE8, 8'hFF, 8'h01, 1'b1, "R5 add carry");
    step(8'hE8, 8'h0F, 8'h01, 1'b1, "R5 add half carry");
    step(8'hEA, 8'h7F, 8'h80, 1'b1, "R5 add carry in");
    step(8'hEE, 8'h10, 8'h20, 1'b1, "R5 subtract");
    step(8'h28, 8'hFF, 8'h01, 1'b1, "R6 carry in xor mode");
    step(8'hA8, 8'h08, 8'h08, 1'b1, "R6 half carry in and mode");
    step(8'h68, 8'h00, 8'h81, 1'b1, "R7 rotate left");
    step(8'h48, 8'h00, 8'hC3, 1'b1, "R7 shift left zero fill");
    step(8'h58, 8'hFF, 8'h40, 1'b1, "R7 shift left one fill");
    step(8'h6A, 8'h00, 8'h81, 1'b1, "R8 rotate right");
    step(8'h4A, 8'hFF, 8'h81, 1'b1, "R8 shift right zero fill");
    step(8'h49, 8'h00, 8'hA7, 1'b1, "R9 swap");
    step(8'h4B, 8'h00, 8'h81, 1'b1, "R10 asr negative");
    step(8'h4B, 8'h00, 8'h42, 1'b1, "R10 asr positive");
    step(8'h6D, 8'h00, 8'hDF, 1'b1, "R11 bit5 clear");
    step(8'h57, 8'h00, 8'h00, 1'b1, "R11 bit2 set");
    step(8'h7F, 8'h00, 8'h7F, 1'b1, "R11 bit7 set");
    step(8'h45, 8'h00, 8'hFE, 1'b1, "R11 bit0 clear");
    step(8'h28, 8'h5A, 8'h5A, 1'b1, "R12 zero result");
    step(8'hE8, 8'h80, 8'h80, 1'b1, "R12 zero with carry");
    step(8'h28, 8'h11, 8'h22, 1'b1, "R13 load");
    step(8'hE8, 8'hFF, 8'hFF, 1'b0, "R13 hold");
    step(8'h4B, 8'h01, 8'h01, 1'b0, "R13 hold second");

    for (int i = 0; i < 400; i++) begin
      step(8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom % 4 != 0), "R2 R3 random");
    end

    finish_run();
  end
endmodule